// File: doc/BRIEF.md
# Thread Context Injector

This block sits between a core's thread scheduler and the on-chip network. When the scheduler decides that a thread must leave the core, it presents one send request. The request carries the thread number, the thread's native core, the destination it wants to reach, the traffic class (self-initiated migration or eviction) and the thread's architectural state. The block works out which node the packet is actually routed to and places the packet on the virtual-channel set that belongs to its class. It then streams the context into the network as one head flit followed by the payload flits.

The routed node depends on a protocol-mode input. In basic mode, every move that does not start at the thread's native core is first sent home. In full mode, a migration goes straight to its target. An eviction always goes home, in both modes, so evicted threads always have a guaranteed landing slot. The two channel sets never share buffers.

A request is taken only when the downstream buffer of its channel set has credits for the whole context. A partially injected context can therefore never block an arriving one. The block keeps one credit counter for each set. Each flit sent lowers the counter of its set, and each returned credit raises it again.

Top module: `mig_ctx_injector`

## Requirements
- R1: After reset no flit is presented (`out_valid` low). Both credit counters hold `BUF_FLITS`, so `req_ready` is high for either class.
- R2: `req_ready` is high only when the sequencer is idle and the credit counter of the class on `req_cls` is at least `CTX_FLITS`. Credits for the head flit alone do not make it high.
- R3: A packet has exactly `CTX_FLITS` flits. Flit 0 is the head, and its layout is: routed node in bits [NODE_W-1:0], final destination in [2*NODE_W-1:NODE_W], thread number in [2*NODE_W+TID_W-1:2*NODE_W], and class in bit 2*NODE_W+TID_W. All higher bits are zero. Flit k (k>=1) is payload word k-1, taken from `req_payload[(k-1)*FLIT_W +: FLIT_W]`. `out_head` marks flit 0 and `out_tail` marks the last flit.
- R4: The head flit appears in the cycle after the request is accepted. The remaining flits follow one per cycle without a gap and without flits of any other packet in between. `req_ready` stays low while a packet is in flight. The cycle after the tail carries no flit.
- R5: `out_vcset` equals the class of the packet (0 = migrating set, 1 = evicted set) and holds for all of its flits.
- R6: An eviction (`req_cls`=1) is routed to `req_native` in either mode.
- R7: In full mode (`route_mode`=1), a migration is routed to `req_dest`.
- R8: In basic mode (`route_mode`=0), a migration is routed to `req_native` when `cur_core` differs from `req_native`, and to `req_dest` when it equals it.
- R9: Each flit sent lowers the counter of its own set by one, and each `credit_ret` bit pulse raises the counter of that set by one. Both in one cycle leave it unchanged. The two sets never affect each other.
- R10: The final-destination field of the head always carries `req_dest`, whatever the routed node is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| route_mode | input | 1 | 0 = detour through native core, 1 = direct migration |
| cur_core | input | NODE_W | Node number of this core |
| req_valid | input | 1 | Send request present |
| req_ready | output | 1 | Request taken at this edge when valid |
| req_cls | input | 1 | 0 = migration, 1 = eviction |
| req_tid | input | TID_W | Thread number |
| req_native | input | NODE_W | Native core of the thread |
| req_dest | input | NODE_W | Destination the thread asks for |
| req_payload | input | (CTX_FLITS-1)*FLIT_W | Thread state, word 0 in the low bits |
| out_valid | output | 1 | A flit is on `out_flit` |
| out_flit | output | FLIT_W | Flit data |
| out_head | output | 1 | First flit of a packet |
| out_tail | output | 1 | Last flit of a packet |
| out_vcset | output | 1 | Channel set of the flit |
| credit_ret | input | 2 | One-cycle credit return, bit 0 migrating set, bit 1 evicted set |

## Verification
The bench builds the block with a four-flit context and a six-flit downstream buffer per set. After one packet, two credits remain: enough for a head flit but not for the context. This lets the bench check the whole-context rule, and step through three credits (still refused) to exactly four (accepted). The same setting makes it cheap to land a credit return on the same edge as a flit of the same set, and to drain one set while the other stays fully available. Both route modes are applied with the current core both equal to and different from the native core.

// File: rtl/mig_inj_pkg.sv
package mig_inj_pkg;

    typedef enum logic {
        VC_MIGRATE = 1'b0,
        VC_EVICT   = 1'b1
    } vcset_e;

    typedef enum logic {
        MODE_BASIC = 1'b0,
        MODE_FULL  = 1'b1
    } route_mode_e;

    localparam int NUM_VC_SETS = 2;

endpackage

// File: rtl/mig_route_sel.sv
module mig_route_sel
    import mig_inj_pkg::*;
#(
    parameter int NODE_W = 6
) (
    input  vcset_e            cls,
    input  route_mode_e       mode,
    input  logic [NODE_W-1:0] cur_core,
    input  logic [NODE_W-1:0] native,
    input  logic [NODE_W-1:0] dest,
    output logic [NODE_W-1:0] routed
);

    logic at_home;

    always_comb begin
        at_home = (cur_core == native);
        routed  = dest;
        if (cls == VC_EVICT) begin
            // evicted threads always go home: the slot there is reserved
            routed = native;
        end else if (mode == MODE_BASIC && !at_home) begin
            // basic mode: leave through the native core
            routed = native;
        end
    end

endmodule

// File: rtl/mig_credit_ctr.sv
module mig_credit_ctr #(
    parameter int BUF_FLITS = 8,
    parameter int CNT_W     = $clog2(BUF_FLITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             give,
    output logic [CNT_W-1:0] count
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctr_t;

    localparam logic [CNT_W-1:0] FULL = CNT_W'(BUF_FLITS);

    ctr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case ({take, give})
            2'b10:   st_d.cnt = st_q.cnt - 1'b1;
            2'b01:   st_d.cnt = st_q.cnt + 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= FULL;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;

endmodule

// File: rtl/mig_flit_seq.sv
module mig_flit_seq #(
    parameter int FLIT_W    = 32,
    parameter int CTX_FLITS = 4,
    parameter int PKT_W     = FLIT_W * CTX_FLITS,
    parameter int IDX_W     = $clog2(CTX_FLITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_set,
    input  logic [PKT_W-1:0]  start_pkt,
    output logic              busy,
    output logic              out_valid,
    output logic [FLIT_W-1:0] out_flit,
    output logic              out_head,
    output logic              out_tail,
    output logic              out_set
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(CTX_FLITS - 1);

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] idx;
        logic             set;
        logic [PKT_W-1:0] pkt;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            st_d.pkt = st_q.pkt >> FLIT_W;
            if (st_q.idx == LAST) begin
                st_d.busy = 1'b0;
                st_d.idx  = '0;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end else if (start) begin
            st_d.busy = 1'b1;
            st_d.idx  = '0;
            st_d.set  = start_set;
            st_d.pkt  = start_pkt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.busy <= 1'b0;
            st_q.idx  <= '0;
            st_q.set  <= 1'b0;
            st_q.pkt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy      = st_q.busy;
    assign out_valid = st_q.busy;
    assign out_flit  = st_q.pkt[FLIT_W-1:0];
    assign out_head  = st_q.busy && (st_q.idx == '0);
    assign out_tail  = st_q.busy && (st_q.idx == LAST);
    assign out_set   = st_q.set;

endmodule

// File: rtl/mig_ctx_injector.sv
module mig_ctx_injector
    import mig_inj_pkg::*;
#(
    parameter int NODE_W    = 6,
    parameter int TID_W     = 6,
    parameter int FLIT_W    = 32,
    parameter int CTX_FLITS = 4,
    parameter int BUF_FLITS = 8,
    parameter int PAY_W     = (CTX_FLITS - 1) * FLIT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              route_mode,
    input  logic [NODE_W-1:0] cur_core,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_cls,
    input  logic [TID_W-1:0]  req_tid,
    input  logic [NODE_W-1:0] req_native,
    input  logic [NODE_W-1:0] req_dest,
    input  logic [PAY_W-1:0]  req_payload,
    output logic              out_valid,
    output logic [FLIT_W-1:0] out_flit,
    output logic              out_head,
    output logic              out_tail,
    output logic              out_vcset,
    input  logic [1:0]        credit_ret
);

    localparam int PKT_W   = FLIT_W * CTX_FLITS;
    localparam int CNT_W   = $clog2(BUF_FLITS + 1);
    localparam int HDR_USE = 2 * NODE_W + TID_W + 1;
    localparam int CLS_BIT = 2 * NODE_W + TID_W;
    localparam logic [CNT_W-1:0] NEED = CNT_W'(CTX_FLITS);

    logic [NODE_W-1:0]      routed;
    logic [FLIT_W-1:0]      hdr_flit;
    logic [PKT_W-1:0]       pkt;
    logic [CNT_W-1:0]       cred [NUM_VC_SETS];
    logic [NUM_VC_SETS-1:0] room;
    logic                   busy;
    logic                   start;

    mig_route_sel #(.NODE_W(NODE_W)) u_route (
        .cls      (vcset_e'(req_cls)),
        .mode     (route_mode_e'(route_mode)),
        .cur_core (cur_core),
        .native   (req_native),
        .dest     (req_dest),
        .routed   (routed)
    );

    for (genvar s = 0; s < NUM_VC_SETS; s++) begin : g_set
        mig_credit_ctr #(.BUF_FLITS(BUF_FLITS), .CNT_W(CNT_W)) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .take  (out_valid && (out_vcset == 1'(s))),
            .give  (credit_ret[s]),
            .count (cred[s])
        );
        // whole-context room, never head-only room
        assign room[s] = (cred[s] >= NEED);
    end

    always_comb begin
        hdr_flit                             = '0;
        hdr_flit[NODE_W-1:0]                 = routed;
        hdr_flit[2*NODE_W-1:NODE_W]          = req_dest;
        hdr_flit[2*NODE_W+TID_W-1:2*NODE_W]  = req_tid;
        hdr_flit[CLS_BIT]                    = req_cls;
        pkt = {req_payload, hdr_flit};
    end

    assign req_ready = !busy && room[req_cls];
    assign start     = req_valid && req_ready;

    mig_flit_seq #(.FLIT_W(FLIT_W), .CTX_FLITS(CTX_FLITS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_set (req_cls),
        .start_pkt (pkt),
        .busy      (busy),
        .out_valid (out_valid),
        .out_flit  (out_flit),
        .out_head  (out_head),
        .out_tail  (out_tail),
        .out_set   (out_vcset)
    );

    if (HDR_USE > FLIT_W) begin : g_bad_cfg
        initial $error("header fields exceed flit width");
    end

endmodule

// File: rtl/mig_ctx_injector_chk.sv
module mig_ctx_injector_chk #(
    parameter int NODE_W    = 6,
    parameter int FLIT_W    = 32,
    parameter int CTX_FLITS = 4,
    parameter int BUF_FLITS = 8,
    parameter int CNT_W     = $clog2(BUF_FLITS + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_cls,
    input logic [NODE_W-1:0] req_native,
    input logic [NODE_W-1:0] req_dest,
    input logic              out_valid,
    input logic [FLIT_W-1:0] out_flit,
    input logic              out_head,
    input logic              out_tail,
    input logic              out_vcset,
    input logic [CNT_W-1:0]  cred_mig,
    input logic [CNT_W-1:0]  cred_evt
);

    logic take;
    assign take = req_valid && req_ready;

    AST_MIG_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !req_cls) |-> (cred_mig >= CNT_W'(CTX_FLITS)));  // R2
    AST_EVT_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        (take && req_cls) |-> (cred_evt >= CNT_W'(CTX_FLITS)));   // R2
    AST_CREDIT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cred_mig <= CNT_W'(BUF_FLITS)) && (cred_evt <= CNT_W'(BUF_FLITS)));  // R9
    AST_HEAD_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (out_valid && out_head));  // R4
    AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_tail) |=> (out_valid && !out_head));  // R4
    AST_TAIL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_tail) |=> !out_valid);  // R4
    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !req_ready);  // R4
    AST_SET_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_tail) |=> $stable(out_vcset));  // R5
    AST_SET_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (out_vcset == $past(req_cls)));  // R5
    AST_EVICT_HOME: assert property (@(posedge clk) disable iff (!rst_n)
        (take && req_cls) |=> (out_flit[NODE_W-1:0] == $past(req_native)));  // R6
    AST_FINAL_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (out_flit[2*NODE_W-1:NODE_W] == $past(req_dest)));  // R10

endmodule

bind mig_ctx_injector mig_ctx_injector_chk #(
    .NODE_W    (NODE_W),
    .FLIT_W    (FLIT_W),
    .CTX_FLITS (CTX_FLITS),
    .BUF_FLITS (BUF_FLITS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_cls    (req_cls),
    .req_native (req_native),
    .req_dest   (req_dest),
    .out_valid  (out_valid),
    .out_flit   (out_flit),
    .out_head   (out_head),
    .out_tail   (out_tail),
    .out_vcset  (out_vcset),
    .cred_mig   (cred[0]),
    .cred_evt   (cred[1])
);

// File: tb/mig_ctx_injector_bench.sv
module mig_ctx_injector_bench;

    localparam int NODE_W    = 6;
    localparam int TID_W     = 6;
    localparam int FLIT_W    = 32;
    localparam int CTX_FLITS = 4;
    localparam int BUF_FLITS = 6;
    localparam int PAY_W     = (CTX_FLITS - 1) * FLIT_W;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              route_mode;
    logic [NODE_W-1:0] cur_core;
    logic              req_valid;
    logic              req_ready;
    logic              req_cls;
    logic [TID_W-1:0]  req_tid;
    logic [NODE_W-1:0] req_native;
    logic [NODE_W-1:0] req_dest;
    logic [PAY_W-1:0]  req_payload;
    logic              out_valid;
    logic [FLIT_W-1:0] out_flit;
    logic              out_head;
    logic              out_tail;
    logic              out_vcset;
    logic [1:0]        credit_ret;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;  // 50 MHz

    mig_ctx_injector #(
        .NODE_W(NODE_W), .TID_W(TID_W), .FLIT_W(FLIT_W),
        .CTX_FLITS(CTX_FLITS), .BUF_FLITS(BUF_FLITS)
    ) u_mig_ctx_injector (
        .clk(clk), .rst_n(rst_n), .route_mode(route_mode), .cur_core(cur_core),
        .req_valid(req_valid), .req_ready(req_ready), .req_cls(req_cls),
        .req_tid(req_tid), .req_native(req_native), .req_dest(req_dest),
        .req_payload(req_payload), .out_valid(out_valid), .out_flit(out_flit),
        .out_head(out_head), .out_tail(out_tail), .out_vcset(out_vcset),
        .credit_ret(credit_ret)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [FLIT_W-1:0] mk_hdr(input logic [NODE_W-1:0] rt,
            input logic [NODE_W-1:0] fin, input logic [TID_W-1:0] tid, input logic cls);
        logic [FLIT_W-1:0] h;
        h = '0;
        h[NODE_W-1:0] = rt;
        h[2*NODE_W-1:NODE_W] = fin;
        h[2*NODE_W+TID_W-1:2*NODE_W] = tid;
        h[2*NODE_W+TID_W] = cls;
        return h;
    endfunction

    function automatic logic [FLIT_W-1:0] pay_word(input logic [TID_W-1:0] tid, input int i);
        return 32'hC0DE_0000 + 32'(tid) * 32'h100 + 32'(i);
    endfunction

    // probe readiness for a class without requesting
    task automatic probe_ready(input logic cls, input logic exp, input string rq, input string what);
        @(negedge clk);
        req_valid = 1'b0;
        req_cls   = cls;
        #1;
        chk(req_ready == exp, rq, what, 64'(req_ready), 64'(exp));
    endtask

    task automatic give_credit(input int set, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            credit_ret[set] = 1'b1;
            @(negedge clk);
            credit_ret[set] = 1'b0;
        end
    endtask

    // one full packet; ret_at >= 0 pulses a credit on the packet's own set
    // across the edge that sends flit ret_at
    task automatic send_ctx(input string rq, input logic cls, input logic mode,
                            input logic [NODE_W-1:0] cur, input logic [NODE_W-1:0] nat,
                            input logic [NODE_W-1:0] dst, input logic [TID_W-1:0] tid,
                            input logic [NODE_W-1:0] exp_rt, input int ret_at);
        logic [FLIT_W-1:0] exp_f;
        @(negedge clk);
        route_mode = mode;
        cur_core   = cur;
        req_cls    = cls;
        req_tid    = tid;
        req_native = nat;
        req_dest   = dst;
        for (int i = 0; i < CTX_FLITS - 1; i++) req_payload[i*FLIT_W +: FLIT_W] = pay_word(tid, i);
        req_valid  = 1'b1;
        #1;
        chk(req_ready == 1'b1, "R2", {rq, " ready before send"}, 64'(req_ready), 64'd1);
        @(posedge clk);
        for (int k = 0; k < CTX_FLITS; k++) begin
            @(negedge clk);
            if (k == 0) req_valid = 1'b1;  // keep asking: must be ignored while busy
            credit_ret[cls] = (k == ret_at);
            #1;
            exp_f = (k == 0) ? mk_hdr(exp_rt, dst, tid, cls) : pay_word(tid, k - 1);
            chk(out_valid == 1'b1, "R4", {rq, " flit valid"}, 64'(out_valid), 64'd1);
            chk(out_flit == exp_f, (k == 0) ? "R3/R6-R8" : "R3", {rq, " flit data"},
                64'(out_flit), 64'(exp_f));
            chk(out_head == (k == 0) && out_tail == (k == CTX_FLITS - 1), "R3",
                {rq, " head/tail"}, {62'd0, out_head, out_tail},
                {62'd0, 1'(k == 0), 1'(k == CTX_FLITS - 1)});
            chk(out_vcset == cls, "R5", {rq, " channel set"}, 64'(out_vcset), 64'(cls));
            chk(req_ready == 1'b0, "R4", {rq, " ready while busy"}, 64'(req_ready), 64'd0);
        end
        @(negedge clk);
        req_valid  = 1'b0;
        credit_ret = '0;
        #1;
        chk(out_valid == 1'b0, "R4", {rq, " gap after tail"}, 64'(out_valid), 64'd0);
    endtask

    task automatic t_reset;
        chk(out_valid == 1'b0, "R1", "no flit after reset", 64'(out_valid), 64'd0);
        probe_ready(1'b0, 1'b1, "R1", "migrate set full after reset");
        probe_ready(1'b1, 1'b1, "R1", "evict set full after reset");
    endtask

    task automatic t_full_direct;
        // R7 R10: full mode, away from home, goes straight to dest
        send_ctx("R7 full direct", 1'b0, 1'b1, 6'd5, 6'd9, 6'd33, 6'd3, 6'd33, -1);
    endtask

    task automatic t_room_boundary;
        // migrate set now holds 2: head-only room, not context room
        probe_ready(1'b0, 1'b0, "R2", "two credits refused");
        probe_ready(1'b1, 1'b1, "R9", "evict set untouched");
        give_credit(0, 1);
        probe_ready(1'b0, 1'b0, "R2", "three credits refused");
        give_credit(0, 1);
        probe_ready(1'b0, 1'b1, "R2", "four credits accepted");
    endtask

    task automatic t_basic_detour;
        // R8 basic, away from home: routed home; credit return overlaps flit 1
        send_ctx("R8 basic detour", 1'b0, 1'b0, 6'd5, 6'd9, 6'd33, 6'd4, 6'd9, 1);
        // 4 - 4 + 1 = 1
        give_credit(0, 2);
        probe_ready(1'b0, 1'b0, "R9", "same-edge return counted once (3)");
        give_credit(0, 1);
        probe_ready(1'b0, 1'b1, "R9", "credit count reaches 4");
    endtask

    task automatic t_basic_from_home;
        send_ctx("R8 basic from home", 1'b0, 1'b0, 6'd9, 6'd9, 6'd40, 6'd7, 6'd40, -1);
        give_credit(0, 4);
    endtask

    task automatic t_evictions;
        send_ctx("R6 evict basic", 1'b1, 1'b0, 6'd5, 6'd12, 6'd20, 6'd11, 6'd12, -1);
        probe_ready(1'b1, 1'b0, "R9", "evict set drained");
        probe_ready(1'b0, 1'b1, "R9", "migrate set unaffected");
        give_credit(1, 4);
        send_ctx("R6 evict full", 1'b1, 1'b1, 6'd12, 6'd30, 6'd12, 6'd21, 6'd30, -1);
        give_credit(1, 4);
    endtask

    initial begin
        rst_n = 1'b0; route_mode = 1'b0; cur_core = '0; req_valid = 1'b0;
        req_cls = 1'b0; req_tid = '0; req_native = '0; req_dest = '0;
        req_payload = '0; credit_ret = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_full_direct();
        t_room_boundary();
        t_basic_detour();
        t_basic_from_home();
        t_evictions();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule